// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves one operand specifier of a variable-length instruction. It takes a 3-bit addressing-mode code, a register number, a constant field and the current program counter. From these it produces one of two things: the operand value itself (immediate and register modes), or the memory address the operand lives at. It also raises a flag that tells the downstream memory stage whether a memory access is needed.

The block reads the general-purpose register file through one combinational read port, driven from the request's register number. The two auto-modifying modes change the pointer register as a side effect, so for them the block issues a register write-back request. Post-increment returns the old pointer and writes back the pointer plus the operand size. Pre-decrement writes back the pointer minus the operand size and uses that same decremented value as the address.

Requests and results move through valid/ready handshakes. Each result appears one cycle after its request is accepted.

Top module: `opnd_ea_gen`

## Requirements
- R1: While reset is held and directly after it, `res_valid` and `wb_valid` are 0 and `req_ready` is 1.
- R2: Mode code 0 (immediate) returns the constant field as `res_value` with `res_mem` = 0.
- R3: Mode code 1 (absolute) returns the constant field as `res_value` with `res_mem` = 1.
- R4: Mode code 2 (register) returns the addressed register's contents with `res_mem` = 0.
- R5: Mode code 3 (register indirect) returns the register's contents unmodified with `res_mem` = 1, and requests no write-back.
- R6: Mode code 4 (indexed) returns register plus constant, modulo 2^32, with `res_mem` = 1.
- R7: Mode code 5 (post-increment) returns the register's old value with `res_mem` = 1, and writes back old value plus `req_size`, modulo 2^32.
- R8: Mode code 6 (pre-decrement) returns register minus `req_size`, modulo 2^32, with `res_mem` = 1, and writes back that same value.
- R9: Mode code 7 (PC-relative) returns `req_pc` plus constant, modulo 2^32, with `res_mem` = 1.
- R10: `wb_valid` is 1 only for modes 5 and 6, and only in the one cycle where `res_valid` and `res_ready` are both 1. In that cycle `wb_reg` is the request's register number.
- R11: A request is accepted when `req_valid` and `req_ready` are both 1, and `res_valid` rises on the next cycle. `req_ready` equals `!res_valid || res_ready`. While a result waits for `res_ready`, it holds stable and new requests have no effect.
- R12: `rf_raddr` always equals `req_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 3 | Addressing-mode code 0..7 |
| req_reg | input | REG_W (4) | Register number of the specifier |
| req_const | input | ADDR_W (32) | Constant field from the instruction stream |
| req_pc | input | ADDR_W (32) | Current program counter |
| req_size | input | SIZE_W (3) | Operand size in bytes (1, 2 or 4) |
| rf_raddr | output | REG_W (4) | Register file read address |
| rf_rdata | input | ADDR_W (32) | Register file read data (combinational) |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_value | output | ADDR_W (32) | Effective address or direct operand |
| res_mem | output | 1 | Memory access needed |
| wb_valid | output | 1 | Pointer write-back request |
| wb_reg | output | REG_W (4) | Register to write back |
| wb_data | output | ADDR_W (32) | Updated pointer value |

## Verification
A corrupted captured mode or value is visible at `res_value` and `res_mem` in the first cycle after acceptance. The bench compares these there against its own per-mode arithmetic. If the pointer update is wrong, the error shows in `wb_data` at the handshake cycle. The bench also reuses a few registers, so the error spreads into later operands that read the updated pointer. A broken hold or ready path shows during forced stalls of random length. In those stalls the result must stay frozen while the bench presents a different request, and `wb_valid` must stay low until the consumer takes the result.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;

  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_ABS  = 3'd1,
    AM_REG  = 3'd2,
    AM_IND  = 3'd3,
    AM_IDX  = 3'd4,
    AM_AINC = 3'd5,
    AM_ADEC = 3'd6,
    AM_REL  = 3'd7
  } amode_e;

  typedef struct packed {
    logic mem;        // operand lives in memory
    logic use_rf;     // register contents take part
    logic use_pc;     // program counter is the base
    logic add_const;  // base plus constant
    logic pre_dec;    // subtract step before use
  } mode_ctl_t;

  function automatic logic mode_writes_back(amode_e m);
    return (m == AM_AINC) || (m == AM_ADEC);
  endfunction

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import opnd_ea_pkg::*;
(
  input  amode_e    mode,
  output mode_ctl_t ctl
);

  always_comb begin
    ctl = '0;
    unique case (mode)
      AM_IMM:  ctl = '0;
      AM_ABS:  ctl.mem = 1'b1;
      AM_REG:  ctl.use_rf = 1'b1;
      AM_IND:  begin ctl.mem = 1'b1; ctl.use_rf = 1'b1; end
      AM_IDX:  begin ctl.mem = 1'b1; ctl.use_rf = 1'b1; ctl.add_const = 1'b1; end
      AM_AINC: begin ctl.mem = 1'b1; ctl.use_rf = 1'b1; end
      AM_ADEC: begin ctl.mem = 1'b1; ctl.use_rf = 1'b1; ctl.pre_dec = 1'b1; end
      AM_REL:  begin ctl.mem = 1'b1; ctl.use_pc = 1'b1; ctl.add_const = 1'b1; end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic          use_rf,
  input  logic          use_pc,
  input  logic          add_const,
  input  logic          pre_dec,
  input  logic [AW-1:0] cnst,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] rdata,
  input  logic [SW-1:0] size,
  output logic [AW-1:0] value,
  output logic [AW-1:0] wb_data
);

  localparam int PADW = AW - SW;

  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] a, logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] wrap_sub(logic [AW-1:0] a, logic [AW-1:0] b);
    return a - b;
  endfunction

  logic [AW-1:0] step;
  logic [AW-1:0] base;
  logic [AW-1:0] sum;
  logic [AW-1:0] dec;
  logic [AW-1:0] inc;

  assign step = {{PADW{1'b0}}, size};
  assign base = use_pc ? pc : rdata;
  assign sum  = wrap_add(base, cnst);
  assign dec  = wrap_sub(rdata, step);
  assign inc  = wrap_add(rdata, step);

  always_comb begin
    if (pre_dec)        value = dec;
    else if (add_const) value = sum;
    else if (use_rf)    value = rdata;
    else                value = cnst;
  end

  assign wb_data = pre_dec ? dec : inc;

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage
  import opnd_ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          drain,
  input  logic [AW-1:0] in_value,
  input  logic          in_mem,
  input  amode_e        in_mode,
  input  logic [RW-1:0] in_reg,
  input  logic [AW-1:0] in_wbd,
  output logic          out_valid,
  output logic [AW-1:0] out_value,
  output logic          out_mem,
  output amode_e        out_mode,
  output logic [RW-1:0] out_reg,
  output logic [AW-1:0] out_wbd
);

  always_ff @(posedge clk) begin
    if (!rst_n)     out_valid <= 1'b0;
    else if (load)  out_valid <= 1'b1;
    else if (drain) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_value <= '0;
      out_mem   <= 1'b0;
      out_mode  <= AM_IMM;
      out_reg   <= '0;
      out_wbd   <= '0;
    end else if (load) begin
      out_value <= in_value;
      out_mem   <= in_mem;
      out_mode  <= in_mode;
      out_reg   <= in_reg;
      out_wbd   <= in_wbd;
    end
  end

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import opnd_ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 4,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [ADDR_W-1:0] req_const,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [SIZE_W-1:0] req_size,
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [ADDR_W-1:0] rf_rdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_value,
  output logic              res_mem,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_reg,
  output logic [ADDR_W-1:0] wb_data
);

  // named internal events for the checker
  logic      accept_w;
  logic      drain_w;
  amode_e    mode_in_w;
  amode_e    mode_q_w;
  mode_ctl_t ctl_w;
  logic [ADDR_W-1:0] calc_value_w;
  logic [ADDR_W-1:0] calc_wbd_w;

  assign mode_in_w = amode_e'(req_mode);
  assign rf_raddr  = req_reg;
  assign req_ready = !res_valid || res_ready;
  assign accept_w  = req_valid && req_ready;
  assign drain_w   = res_valid && res_ready;

  ea_mode_decode u_dec (
    .mode (mode_in_w),
    .ctl  (ctl_w)
  );

  ea_addr_calc #(.AW(ADDR_W), .SW(SIZE_W)) u_calc (
    .use_rf    (ctl_w.use_rf),
    .use_pc    (ctl_w.use_pc),
    .add_const (ctl_w.add_const),
    .pre_dec   (ctl_w.pre_dec),
    .cnst      (req_const),
    .pc        (req_pc),
    .rdata     (rf_rdata),
    .size      (req_size),
    .value     (calc_value_w),
    .wb_data   (calc_wbd_w)
  );

  ea_out_stage #(.AW(ADDR_W), .RW(REG_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_w),
    .drain     (drain_w),
    .in_value  (calc_value_w),
    .in_mem    (ctl_w.mem),
    .in_mode   (mode_in_w),
    .in_reg    (req_reg),
    .in_wbd    (calc_wbd_w),
    .out_valid (res_valid),
    .out_value (res_value),
    .out_mem   (res_mem),
    .out_mode  (mode_q_w),
    .out_reg   (wb_reg),
    .out_wbd   (wb_data)
  );

  assign wb_valid = drain_w && mode_writes_back(mode_q_w);

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import opnd_ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [REG_W-1:0]  req_reg,
  input logic [REG_W-1:0]  rf_raddr,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_value,
  input logic              res_mem,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_data,
  input logic              accept_w,
  input amode_e            mode_q_w
);

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> req_ready); // R11

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid); // R11

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_value) && $stable(res_mem))); // R11

  AST_WB_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (res_valid && res_ready)); // R10

  AST_WB_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (mode_q_w == AM_AINC || mode_q_w == AM_ADEC)); // R10

  AST_IMM_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_q_w == AM_IMM) |-> !res_mem); // R2

  AST_REG_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_q_w == AM_REG) |-> !res_mem); // R4

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_q_w == AM_AINC) |-> ($countones(wb_data - res_value) == 1)); // R7

  AST_DEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_q_w == AM_ADEC) |-> (wb_data == res_value)); // R8

  AST_READ_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_raddr == req_reg); // R12

  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !accept_w); // R11

endmodule

bind opnd_ea_gen ea_gen_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_opnd_ea_gen.sv
module sim_opnd_ea_gen;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int RW = 4;
  localparam int SW = 3;
  localparam int NREG = 1 << RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_mode = '0;
  logic [RW-1:0] req_reg = '0;
  logic [AW-1:0] req_const = '0;
  logic [AW-1:0] req_pc = '0;
  logic [SW-1:0] req_size = 3'd1;
  logic [RW-1:0] rf_raddr;
  logic [AW-1:0] rf_rdata;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [AW-1:0] res_value;
  logic          res_mem;
  logic          wb_valid;
  logic [RW-1:0] wb_reg;
  logic [AW-1:0] wb_data;

  logic [AW-1:0] rf_m [NREG];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata = rf_m[rf_raddr];

  opnd_ea_gen u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected result per mode, written from the requirement list
  function automatic void model(input logic [2:0] m, input logic [AW-1:0] rv,
                                input logic [AW-1:0] c, input logic [AW-1:0] pc,
                                input logic [SW-1:0] sz,
                                output logic [AW-1:0] v, output bit mem,
                                output bit wb, output logic [AW-1:0] wbd);
    logic [AW:0] wide;
    wb = 0; wbd = '0; mem = 1;
    case (m)
      3'd0: begin v = c; mem = 0; end
      3'd1: v = c;
      3'd2: begin v = rv; mem = 0; end
      3'd3: v = rv;
      3'd4: begin wide = {1'b0, rv} + {1'b0, c}; v = wide[AW-1:0]; end
      3'd5: begin v = rv; wb = 1; wbd = rv + AW'(sz); end
      3'd6: begin wbd = rv + ~AW'(sz) + 1; v = wbd; wb = 1; end
      default: begin wide = {1'b0, pc} + {1'b0, c}; v = wide[AW-1:0]; end
    endcase
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5";
      3'd4: return "R6"; 3'd5: return "R7"; 3'd6: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] m, input logic [RW-1:0] r,
                        input logic [AW-1:0] c, input logic [AW-1:0] pc,
                        input logic [SW-1:0] sz, input int hold);
    logic [AW-1:0] ev, ewd;
    bit emem, ewb;
    string t;
    t = tag(m);
    @(negedge clk);
    req_mode = m; req_reg = r; req_const = c; req_pc = pc; req_size = sz; req_valid = 1'b1;
    model(m, rf_m[r], c, pc, sz, ev, emem, ewb, ewd);
    #1;
    chk(req_ready == 1'b1, "R11 ready idle", AW'(req_ready), 1);
    chk(rf_raddr == r, "R12 read addr", AW'(rf_raddr), AW'(r));
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid == 1'b1, "R11 valid after accept", AW'(res_valid), 1);
    chk(res_value == ev, {t, " value"}, res_value, ev);
    chk(res_mem == emem, {t, " mem flag"}, AW'(res_mem), AW'(emem));
    chk(wb_valid == 1'b0, "R10 no wb before ready", AW'(wb_valid), 0);
    for (int i = 0; i < hold; i++) begin
      // foreign request while stalled must have no effect
      req_valid = 1'b1; req_mode = ~m; req_const = ~c; req_reg = r + 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R11 not ready stalled", AW'(req_ready), 0);
      chk(res_valid && res_value == ev && res_mem == emem, "R11 hold stable", res_value, ev);
      chk(wb_valid == 1'b0, "R10 no wb while stalled", AW'(wb_valid), 0);
    end
    req_valid = 1'b0;
    res_ready = 1'b1;
    #1;
    chk(wb_valid == ewb, "R10 wb valid", AW'(wb_valid), AW'(ewb));
    if (ewb) begin
      chk(wb_reg == r, "R10 wb reg", AW'(wb_reg), AW'(r));
      chk(wb_data == ewd, {t, " wb data"}, wb_data, ewd);
      rf_m[r] = ewd;
    end
    if (m == 3'd3) chk(wb_valid == 1'b0, "R5 no wb", AW'(wb_valid), 0);
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R11 drained", AW'(res_valid), 0);
    chk(wb_valid == 1'b0, "R10 wb one cycle", AW'(wb_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] sizes [3];
    sizes[0] = 3'd1; sizes[1] = 3'd2; sizes[2] = 3'd4;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) rf_m[i] = $urandom;
    rf_m[1] = 32'hFFFF_FFFE;
    rf_m[2] = 32'h0000_0000;
    rf_m[3] = 32'h0000_1000;

    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid in reset", AW'(res_valid), 0);
    chk(wb_valid == 1'b0, "R1 wb in reset", AW'(wb_valid), 0);
    chk(req_ready == 1'b1, "R1 ready in reset", AW'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0 && req_ready == 1'b1, "R1 after reset", AW'(res_valid), 0);

    // directed corners
    run_op(3'd0, 4'd5, 32'hDEAD_BEEF, 32'h100, 3'd4, 0);
    run_op(3'd1, 4'd5, 32'h0000_8000, 32'h100, 3'd4, 1);
    run_op(3'd2, 4'd3, 32'h1234, 32'h100, 3'd4, 0);
    run_op(3'd3, 4'd3, 32'h1234, 32'h100, 3'd4, 2);
    run_op(3'd4, 4'd1, 32'h0000_0005, 32'h100, 3'd4, 0);   // index wrap
    run_op(3'd5, 4'd1, 32'h0, 32'h100, 3'd4, 0);           // post-inc wrap
    run_op(3'd5, 4'd1, 32'h0, 32'h100, 3'd2, 1);           // reads updated pointer
    run_op(3'd6, 4'd2, 32'h0, 32'h100, 3'd1, 0);           // pre-dec below zero
    run_op(3'd6, 4'd2, 32'h0, 32'h100, 3'd4, 3);
    run_op(3'd7, 4'd0, 32'hFFFF_FFF0, 32'h0000_0020, 3'd4, 0); // negative displacement
    run_op(3'd7, 4'd0, 32'h10, 32'hFFFF_FFF8, 3'd4, 1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      run_op(3'($urandom_range(0, 7)), RW'($urandom_range(0, 3)), $urandom, $urandom,
             sizes[$urandom_range(0, 2)], $urandom_range(0, 3));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule